// File: doc/BRIEF.md
# I2C SCL Clock Divider Chain

This block turns a fast system clock into the bit-timing base of an I2C master. Three programmable stages divide the system clock. The first is a half-period counter that flips an internal clock each time it has counted through its programmed value. The second is a power-of-two prescaler. The third is a linear divider. Together they produce a one-cycle sample-tick strobe. Ten sample ticks form one SCL period: for five tick intervals the block asks for SCL to be pulled low, and for the next five it releases the line.

Two configuration inputs feed the chain. One carries the 8-bit half-period value. The other is a control byte that packs the linear divider and the prescaler exponent. Software computes these values for the target rate; the block only applies them. A new setting takes effect only at the end of a full SCL period, so the waveform never shows a shortened or stretched phase. While the line is released, a device that holds SCL low freezes the chain. This is how clock stretching is honoured.

Top module: `sclClockDivider`

## Requirements
- R1: While reset is asserted, and directly after it, sclDriveLow is 1, sclHigh is 0 and sampleTick is 0. The active setting starts as half-period 0x18, linear divider 2 and prescaler exponent 0, which gives a tick every 150 system cycles.
- R2: With active half-period H, exponent N and linear divider M, sampleTick pulses for exactly one cycle every 2·(H+1)·2^N·(M+1) system cycles. Examples: 36 cycles for H=5, N=0, M=2; 256 cycles for H=7, N=2, M=3; 1536 cycles for H=255, N=0, M=2.
- R3: The control byte carries the linear divider M in bits 6:3 and the prescaler exponent N in bits 2:0.
- R4: A half-period value below 5 is applied as 5.
- R5: A linear divider value below 2 is applied as 2.
- R6: The ticks are numbered 1 to 10 from each period boundary. sclDriveLow is 1 and sclHigh is 0 from a boundary tick until tick 5. sclDriveLow is 0 and sclHigh is 1 from tick 5 until tick 10, which is the next boundary. Both outputs change only in the cycle of a sampleTick pulse.
- R7: A change on either configuration input is latched only by the tick that completes a period. Ticks before that tick keep the old interval, and every tick interval of the next period uses the new one.
- R8: During the released phase, every cycle in which sclIn is low holds all divider counters. The pending tick interval grows by exactly that number of cycles, and no sampleTick is issued in the cycle after a held cycle.
- R9: sclIn being low during the drive-low phase has no effect on tick timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| halfPeriodCfg | input | 8 | Half-period count H |
| clkCtrlCfg | input | 7 | Control byte: M in bits 6:3, N in bits 2:0 |
| sclIn | input | 1 | Sensed SCL line level, synchronous to clk |
| sampleTick | output | 1 | One-cycle strobe, ten per SCL period |
| sclDriveLow | output | 1 | 1 while SCL is to be pulled low |
| sclHigh | output | 1 | 1 during the released (high) phase |

## Verification
The divider is run with several settings, each held for a full period. A small half-period with no prescaling tests the first stage in isolation. A mixed setting with prescaler and linear divider both above their minimum shows whether the 2^N and M+1 factors are decoded from the right bits and multiplied rather than added. Values below the floors are compared against the interval of the clamped setting. The largest half-period checks that the counter wraps correctly at full width. Every setting is written just after a period boundary, and the old interval is expected for all ten ticks that follow, which separates boundary-only loading from immediate loading. A line hold placed in the high phase must add exactly its length to one interval, while an equal hold in the low phase must change nothing.

// File: rtl/sclDivPkg.sv
package sclDivPkg;

  // Field widths of the divider setting
  localparam int THP_W   = 8;
  localparam int PRESC_W = 3;
  localparam int MDIV_W  = 4;
  localparam int CTRL_W  = PRESC_W + MDIV_W;

  // One complete divider setting
  typedef struct packed {
    logic [THP_W-1:0]   halfPeriod;
    logic [PRESC_W-1:0] prescExp;
    logic [MDIV_W-1:0]  linDiv;
  } divCfgT;

  // Strobes from control to datapath
  typedef struct packed {
    logic holdCount;   // freeze every counter this cycle
    logic cfgLoad;     // adopt the staged setting at this edge
  } ctrlStrobeT;

endpackage

// File: rtl/sclDivCtrl.sv
module sclDivCtrl
  import sclDivPkg::*;
#(
  parameter int THP_MIN          = 5,
  parameter int MDIV_MIN         = 2,
  parameter int TICKS_PER_PERIOD = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [THP_W-1:0]   halfPeriodCfg,
  input  logic [CTRL_W-1:0]  clkCtrlCfg,
  input  logic               sclIn,
  input  logic               tickNow,
  output divCfgT             stagedCfg,
  output ctrlStrobeT         strobe,
  output logic               sampleTick,
  output logic               sclDriveLow,
  output logic               sclHigh
);

  localparam int IDX_W = $clog2(TICKS_PER_PERIOD);
  localparam logic [IDX_W-1:0]   IDX_LAST   = IDX_W'(TICKS_PER_PERIOD - 1);
  localparam logic [IDX_W-1:0]   IDX_HALF   = IDX_W'(TICKS_PER_PERIOD / 2);
  localparam logic [THP_W-1:0]   THP_FLOOR  = THP_W'(THP_MIN);
  localparam logic [MDIV_W-1:0]  MDIV_FLOOR = MDIV_W'(MDIV_MIN);

  logic [IDX_W-1:0]   tickIdx;
  logic [MDIV_W-1:0]  linRaw;
  logic [PRESC_W-1:0] prescRaw;
  logic               phaseHigh;
  logic               lastTick;

  // Field decode of the control byte: linear divider above the exponent
  assign linRaw   = clkCtrlCfg[PRESC_W +: MDIV_W];
  assign prescRaw = clkCtrlCfg[PRESC_W-1:0];

  // Clamp to the usable range before staging
  always_comb begin
    stagedCfg.halfPeriod = (halfPeriodCfg < THP_FLOOR) ? THP_FLOOR : halfPeriodCfg;
    stagedCfg.linDiv     = (linRaw < MDIV_FLOOR) ? MDIV_FLOOR : linRaw;
    stagedCfg.prescExp   = prescRaw;
  end

  assign phaseHigh = (tickIdx >= IDX_HALF);
  assign lastTick  = (tickIdx == IDX_LAST);

  // Stretching: released phase but line still low
  assign strobe.holdCount = phaseHigh && !sclIn;
  assign strobe.cfgLoad   = tickNow && lastTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickIdx    <= '0;
      sampleTick <= 1'b0;
    end else begin
      sampleTick <= tickNow;
      if (tickNow) begin
        tickIdx <= lastTick ? '0 : tickIdx + 1'b1;
      end
    end
  end

  assign sclDriveLow = !phaseHigh;
  assign sclHigh     = phaseHigh;

endmodule

// File: rtl/sclDivDatapath.sv
module sclDivDatapath
  import sclDivPkg::*;
#(
  parameter int THP_RST   = 24,
  parameter int MDIV_RST  = 2,
  parameter int PRESC_RST = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  divCfgT     stagedCfg,
  input  ctrlStrobeT strobe,
  output logic       tickNow
);

  // Prescaler count reaches 2^N - 1 at most
  localparam int PCNT_W = (1 << PRESC_W) - 1;

  divCfgT              activeCfg;
  logic [THP_W-1:0]    halfCnt;
  logic                halfLvl;
  logic [PCNT_W-1:0]   prescCnt;
  logic [PCNT_W-1:0]   prescTop;
  logic [MDIV_W-1:0]   linCnt;
  logic                halfEnd;
  logic                cycleEnd;
  logic                prescEnd;
  logic                linEnd;

  assign prescTop = PCNT_W'((32'd1 << activeCfg.prescExp) - 32'd1);

  assign halfEnd  = (halfCnt == activeCfg.halfPeriod);
  assign cycleEnd = halfEnd && halfLvl;
  assign prescEnd = (prescCnt == prescTop);
  assign linEnd   = (linCnt == activeCfg.linDiv);
  assign tickNow  = cycleEnd && prescEnd && linEnd && !strobe.holdCount;

  // Active setting, swapped only on the boundary strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeCfg.halfPeriod <= THP_W'(THP_RST);
      activeCfg.linDiv     <= MDIV_W'(MDIV_RST);
      activeCfg.prescExp   <= PRESC_W'(PRESC_RST);
    end else if (strobe.cfgLoad) begin
      activeCfg <= stagedCfg;
    end
  end

  // Stage 1: half-period counter toggling an internal clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt <= '0;
      halfLvl <= 1'b0;
    end else if (!strobe.holdCount) begin
      if (halfEnd) begin
        halfCnt <= '0;
        halfLvl <= ~halfLvl;
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  // Stage 2: power-of-two prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescCnt <= '0;
    end else if (!strobe.holdCount && cycleEnd) begin
      prescCnt <= prescEnd ? '0 : prescCnt + 1'b1;
    end
  end

  // Stage 3: linear divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linCnt <= '0;
    end else if (!strobe.holdCount && cycleEnd && prescEnd) begin
      linCnt <= linEnd ? '0 : linCnt + 1'b1;
    end
  end

endmodule

// File: rtl/sclClockDivider.sv
module sclClockDivider
  import sclDivPkg::*;
#(
  parameter int THP_MIN          = 5,
  parameter int MDIV_MIN         = 2,
  parameter int THP_RST          = 24,
  parameter int MDIV_RST         = 2,
  parameter int PRESC_RST        = 0,
  parameter int TICKS_PER_PERIOD = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [THP_W-1:0]  halfPeriodCfg,
  input  logic [CTRL_W-1:0] clkCtrlCfg,
  input  logic              sclIn,
  output logic              sampleTick,
  output logic              sclDriveLow,
  output logic              sclHigh
);

  divCfgT     stagedCfg;
  ctrlStrobeT strobe;
  logic       tickNow;

  sclDivCtrl #(
    .THP_MIN          (THP_MIN),
    .MDIV_MIN         (MDIV_MIN),
    .TICKS_PER_PERIOD (TICKS_PER_PERIOD)
  ) ctrlInst (
    .clk           (clk),
    .rstN          (rstN),
    .halfPeriodCfg (halfPeriodCfg),
    .clkCtrlCfg    (clkCtrlCfg),
    .sclIn         (sclIn),
    .tickNow       (tickNow),
    .stagedCfg     (stagedCfg),
    .strobe        (strobe),
    .sampleTick    (sampleTick),
    .sclDriveLow   (sclDriveLow),
    .sclHigh       (sclHigh)
  );

  sclDivDatapath #(
    .THP_RST   (THP_RST),
    .MDIV_RST  (MDIV_RST),
    .PRESC_RST (PRESC_RST)
  ) dpInst (
    .clk       (clk),
    .rstN      (rstN),
    .stagedCfg (stagedCfg),
    .strobe    (strobe),
    .tickNow   (tickNow)
  );

endmodule

// File: rtl/sclClockDivider_checker.sv
module sclClockDivider_checker #(
  parameter int TICKS_PER_PERIOD = 10,
  parameter int MIN_GAP          = 36
) (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sampleTick,
  input logic sclDriveLow,
  input logic sclHigh
);

  logic [3:0]  seenIdx;
  logic [3:0]  effIdx;
  logic [15:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenIdx <= '0;
      gapCnt  <= '0;
    end else begin
      if (sampleTick) begin
        seenIdx <= (seenIdx == 4'(TICKS_PER_PERIOD - 1)) ? '0 : seenIdx + 1'b1;
        gapCnt  <= '0;
      end else if (gapCnt != 16'hFFFF) begin
        gapCnt <= gapCnt + 1'b1;
      end
    end
  end

  assign effIdx = sampleTick ?
                  ((seenIdx == 4'(TICKS_PER_PERIOD - 1)) ? 4'd0 : seenIdx + 1'b1) :
                  seenIdx;

  assert_reset_state_R1: assert property (@(posedge clk)
    !rstN |-> (sclDriveLow && !sclHigh && !sampleTick));

  assert_single_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    sampleTick |=> !sampleTick);

  assert_min_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    sampleTick |-> (gapCnt >= 16'(MIN_GAP - 1)));

  assert_phase_on_tick_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclDriveLow) |-> sampleTick);

  assert_phase_model_R6: assert property (@(posedge clk) disable iff (!rstN)
    sclDriveLow == (effIdx < 4'(TICKS_PER_PERIOD / 2)));

  assert_stretch_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sclHigh && !sclIn) |=> !sampleTick);

endmodule

bind sclClockDivider sclClockDivider_checker #(
  .TICKS_PER_PERIOD (TICKS_PER_PERIOD)
) checkerInst (
  .clk         (clk),
  .rstN        (rstN),
  .sclIn       (sclIn),
  .sampleTick  (sampleTick),
  .sclDriveLow (sclDriveLow),
  .sclHigh     (sclHigh)
);

// File: tb/sclClockDivider_test.sv
module sclClockDivider_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] halfPeriodCfg;
  logic [6:0] clkCtrlCfg;
  logic       extHold;
  logic       sclIn;
  logic       sampleTick;
  logic       sclDriveLow;
  logic       sclHigh;

  always #4 clk = ~clk;  // 125 MHz

  // Wired-AND line model: low when driven or held externally
  assign sclIn = !(sclDriveLow || extHold);

  sclClockDivider uut (
    .clk           (clk),
    .rstN          (rstN),
    .halfPeriodCfg (halfPeriodCfg),
    .clkCtrlCfg    (clkCtrlCfg),
    .sclIn         (sclIn),
    .sampleTick    (sampleTick),
    .sclDriveLow   (sclDriveLow),
    .sclHigh       (sclHigh)
  );

  typedef struct {
    longint iv;
    string  tag;
  } expT;

  expT    expQ[$];
  int     checks = 0;
  int     errors = 0;
  int     benchIdx = 0;
  longint cycleCnt = 0;
  longint lastTick = 0;
  logic   prevTick = 1'b0;
  event   boundaryEv;

  task automatic checkEq(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) cycleCnt++;

  // Monitor: pops expected intervals and checks phase per tick
  always @(negedge clk) begin
    if (rstN) begin
      if (sampleTick) begin
        expT e;
        benchIdx = (benchIdx + 1) % 10;
        checkEq("R6 drive-low phase", longint'(sclDriveLow), longint'(benchIdx < 5));
        checkEq("R6 high phase", longint'(sclHigh), longint'(benchIdx >= 5));
        checkEq("R2 single-cycle tick", longint'(prevTick), 0);
        if (expQ.size() > 0) begin
          e = expQ.pop_front();
          checkEq(e.tag, cycleCnt - lastTick, e.iv);
        end
        lastTick = cycleCnt;
        if (benchIdx == 0) -> boundaryEv;
      end
      prevTick = sampleTick;
    end
  end

  task automatic pushOne(input longint iv, input string tag);
    expT e;
    e.iv  = iv;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic pushPeriod(input longint iv, input string tag);
    for (int i = 0; i < 10; i++) pushOne(iv, tag);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
  endtask

  // Write a new setting just after a boundary; the running period keeps oldIv
  task automatic stepTo(input int thp, input int m, input int n,
                        input longint oldIv, input string tag);
    halfPeriodCfg = 8'(thp);
    clkCtrlCfg    = {4'(m), 3'(n)};
    pushPeriod(oldIv, tag);
    drain();
  endtask

  task automatic waitIdx(input int idx);
    while (benchIdx != idx) @(negedge clk);
  endtask

  initial begin
    rstN          = 1'b0;
    halfPeriodCfg = 8'h18;
    clkCtrlCfg    = {4'd2, 3'd0};
    extHold       = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkEq("R1 reset drive low", longint'(sclDriveLow), 1);
    checkEq("R1 reset high phase", longint'(sclHigh), 0);
    checkEq("R1 reset tick", longint'(sampleTick), 0);
    rstN = 1'b1;

    @(boundaryEv);
    stepTo(5, 2, 0, 150, "R1 default interval / R7 hold old");
    stepTo(7, 3, 2, 36, "R2 H5N0M2 / R7 hold old");
    stepTo(2, 0, 1, 256, "R3 fields H7N2M3 / R7 hold old");
    stepTo(5, 2, 0, 72, "R4 R5 clamped H2M0N1");

    // Stretching period at 36 cycles per tick
    pushOne(36, "R2 base");
    pushOne(36, "R9 low-phase hold ignored");
    for (int i = 0; i < 3; i++) pushOne(36, "R2 base");
    pushOne(76, "R8 stretch adds 40");
    for (int i = 0; i < 4; i++) pushOne(36, "R2 base");
    waitIdx(1);
    repeat (3) @(negedge clk);
    extHold = 1'b1;
    repeat (20) @(negedge clk);
    extHold = 1'b0;
    waitIdx(5);
    repeat (3) @(negedge clk);
    extHold = 1'b1;
    repeat (40) @(negedge clk);
    extHold = 1'b0;
    drain();

    stepTo(255, 2, 0, 36, "R7 hold old after stretch");
    pushPeriod(1536, "R2 H255N0M2");
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule